// File: doc/BRIEF.md
# Escalating Two-Stage Watchdog

This block is a supervision counter clocked by the oscillator. Software must strobe a clear input at regular intervals. If the count reaches the end of the selected period without a clear, the block emits a one-cycle non-maskable interrupt pulse and raises a warning flag. If the next period also runs out with no clear in between, the block asserts a reset request. The request stays high until the system reset that it asks for.

The period is a power of two, picked by a small select code. The code is captured only when a clear happens, so a change in the middle of a period cannot shorten or stretch the period that is already counting. Driving the enable low stops supervision completely: the count sits at zero and a pending warning is dropped. Interrupt delivery and reset generation are done by other blocks downstream, which take the pulse and the request from here.

Top module: `escalating_watchdog`

## Requirements
- R1: After reset, the interrupt pulse, the reset request and the warning flag are all low.
- R2: With select code s (0 to 4), the period is L = 2^(BASE_LOG2 + STEP_LOG2*s) clock cycles. When clear is sampled high at clock edge k and no further clear follows, the interrupt pulse is high during the cycle that follows edge k+L.
- R3: Select codes 5, 6 and 7 give the same period as code 4.
- R4: The first overflow produces an interrupt pulse exactly one cycle wide and sets the warning flag.
- R5: A second overflow with no clear since the first sets the reset request at edge k+2L, with no further interrupt pulse. The request then stays high through clears and through disable, and only reset removes it.
- R6: A clear sets the count back to zero and drops the warning flag. The overflow that follows a clear is again treated as a first overflow.
- R7: A clear sampled in the same cycle in which the count would wrap takes priority. No overflow is recorded and no interrupt pulse follows.
- R8: A new select code has no effect on the period that is running. It is applied by the next clear, by reset, or while the block is disabled.
- R9: While enable is low, the count holds at zero, the warning flag is cleared, and no interrupt pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Supervision enable |
| period_sel | input | SEL_W | Period code, captured on clear |
| kick | input | 1 | Software clear strobe |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |
| reset_req | output | 1 | Sticky hard-reset request |
| warned | output | 1 | First overflow pending (or tripped) |

## Verification
The clear strobe and the counter wrap can fall in the same cycle. The bench provokes this by counting L-1 edges after a clear and then holding the clear high for the one cycle in which the count sits at its terminal value. It then judges the result at the ports: the interrupt pulse must stay low, the warning flag must stay low, and the next interrupt must arrive exactly L cycles after that late clear. For every select code, the bench also checks the full escalation sequence against periods computed arithmetically from the code.

// File: rtl/ewd_pkg.sv
package ewd_pkg;

    typedef enum logic [1:0] {
        WD_CLEAN   = 2'd0,
        WD_WARNED  = 2'd1,
        WD_TRIPPED = 2'd2
    } ewd_state_e;

    typedef struct packed {
        logic nmi;
        logic reset_req;
        logic warned;
    } ewd_flags_t;

    // Codes beyond the last period fall back to the longest one.
    function automatic int unsigned clamp_sel(int unsigned sel, int unsigned num);
        return (sel >= num) ? (num - 1) : sel;
    endfunction

    function automatic int unsigned period_log2(int unsigned base, int unsigned step,
                                                int unsigned sel);
        return base + step * sel;
    endfunction

endpackage

// File: rtl/ewd_period_latch.sv
module ewd_period_latch #(
    parameter int NUM_PERIODS = 5,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             kick,
    input  logic [SEL_W-1:0] period_sel,
    output logic [SEL_W-1:0] active_sel
);
    import ewd_pkg::*;

    logic [SEL_W-1:0] sel_clamped;

    always_comb begin
        sel_clamped = SEL_W'(clamp_sel(int'(period_sel), NUM_PERIODS));
    end

    always_ff @(posedge clk) begin
        if (rst || kick || !en) begin
            active_sel <= sel_clamped;
        end
    end

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(active_sel) < NUM_PERIODS); // R3

endmodule

// File: rtl/ewd_counter.sv
module ewd_counter #(
    parameter int BASE_LOG2   = 16,
    parameter int STEP_LOG2   = 2,
    parameter int NUM_PERIODS = 5,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             kick,
    input  logic [SEL_W-1:0] active_sel,
    output logic             wrap
);
    import ewd_pkg::*;

    localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NUM_PERIODS - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] terminal;

    always_comb begin
        terminal = {CNT_W{1'b1}} >>
                   (CNT_W - int'(period_log2(BASE_LOG2, STEP_LOG2, int'(active_sel))));
    end

    // A clear in the terminal cycle wins over the wrap.
    assign wrap = en && !kick && (cnt == terminal);

    always_ff @(posedge clk) begin
        if (rst || !en || kick) begin
            cnt <= '0;
        end else if (cnt == terminal) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= terminal); // R2
    AST_KICK_ZEROES: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == '0)); // R6
    AST_NO_WRAP_ON_KICK: assert property (@(posedge clk) disable iff (rst)
        kick |-> !wrap); // R7
    AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0)); // R9

endmodule

// File: rtl/ewd_escalate.sv
module ewd_escalate (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                kick,
    input  logic                wrap,
    output ewd_pkg::ewd_flags_t flags
);
    import ewd_pkg::*;

    ewd_state_e state;
    logic       nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WD_CLEAN;
            nmi_q <= 1'b0;
        end else begin
            nmi_q <= 1'b0;
            if (state == WD_TRIPPED) begin
                state <= WD_TRIPPED;
            end else if (!en || kick) begin
                state <= WD_CLEAN;
            end else if (wrap) begin
                if (state == WD_CLEAN) begin
                    state <= WD_WARNED;
                    nmi_q <= 1'b1;
                end else begin
                    state <= WD_TRIPPED;
                end
            end
        end
    end

    always_comb begin
        flags.nmi       = nmi_q;
        flags.reset_req = (state == WD_TRIPPED);
        flags.warned    = (state != WD_CLEAN);
    end

    AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (rst)
        flags.nmi |=> !flags.nmi); // R4
    AST_NMI_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
        flags.nmi |-> (flags.warned && !$past(flags.warned))); // R4
    AST_RST_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags.reset_req |=> flags.reset_req); // R5
    AST_TRIP_AFTER_WARN: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.reset_req) |-> $past(flags.warned)); // R5
    AST_OFF_NO_NMI: assert property (@(posedge clk) disable iff (rst)
        !en |=> !flags.nmi); // R9

endmodule

// File: rtl/escalating_watchdog.sv
module escalating_watchdog #(
    parameter int BASE_LOG2   = 16,
    parameter int STEP_LOG2   = 2,
    parameter int NUM_PERIODS = 5,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             kick,
    output logic             nmi_pulse,
    output logic             reset_req,
    output logic             warned
);
    import ewd_pkg::*;

    logic [SEL_W-1:0] active_sel;
    logic             wrap;
    ewd_flags_t       flags;

    ewd_period_latch #(
        .NUM_PERIODS(NUM_PERIODS),
        .SEL_W      (SEL_W)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .kick      (kick),
        .period_sel(period_sel),
        .active_sel(active_sel)
    );

    ewd_counter #(
        .BASE_LOG2  (BASE_LOG2),
        .STEP_LOG2  (STEP_LOG2),
        .NUM_PERIODS(NUM_PERIODS),
        .SEL_W      (SEL_W)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .kick      (kick),
        .active_sel(active_sel),
        .wrap      (wrap)
    );

    ewd_escalate u_escalate (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .kick (kick),
        .wrap (wrap),
        .flags(flags)
    );

    assign nmi_pulse = flags.nmi;
    assign reset_req = flags.reset_req;
    assign warned    = flags.warned;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!nmi_pulse && !reset_req && !warned)); // R1

endmodule

// File: tb/tb_escalating_watchdog.sv
`timescale 1ns/1ps
module tb_escalating_watchdog;

    localparam int BASE = 4;
    localparam int STEP = 1;
    localparam int NUM  = 5;
    localparam int SW   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [SW-1:0] period_sel = '0;
    logic          kick = 1'b0;
    logic          nmi_pulse, reset_req, warned;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    escalating_watchdog #(
        .BASE_LOG2(BASE), .STEP_LOG2(STEP), .NUM_PERIODS(NUM), .SEL_W(SW)
    ) dut (
        .clk(clk), .rst(rst), .en(en), .period_sel(period_sel), .kick(kick),
        .nmi_pulse(nmi_pulse), .reset_req(reset_req), .warned(warned)
    );

    function automatic int plen(int sel);
        int s;
        s = (sel >= NUM) ? NUM - 1 : sel;
        return 1 << (BASE + STEP * s);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc();
        rst = 1'b0;
    endtask

    task automatic do_kick(int sel);
        period_sel = SW'(sel);
        kick = 1'b1;
        cyc();
        kick = 1'b0;
    endtask

    // Counts edges until the first interrupt pulse; 0 if none within max.
    task automatic wait_nmi(int max, output int n);
        n = 0;
        for (int i = 1; i <= max; i++) begin
            cyc();
            if (nmi_pulse) begin
                n = i;
                break;
            end
        end
    endtask

    initial begin
        int n, l, trip, extra;
        @(negedge clk);
        cyc();
        cyc();
        chk("R1 nmi after reset", int'(nmi_pulse), 0);
        chk("R1 reset_req after reset", int'(reset_req), 0);
        chk("R1 warned after reset", int'(warned), 0);
        rst = 1'b0;
        en = 1'b1;

        // Sweep all select codes: full escalation sequence.
        for (int s = 0; s < 8; s++) begin
            period_sel = SW'(s);
            do_reset();
            l = plen(s);
            do_kick(s);
            wait_nmi(2 * l, n);
            chk((s < NUM) ? "R2 first overflow cycle" : "R3 clamped period", n, l);
            chk("R4 warned after first overflow", int'(warned), 1);
            chk("R5 no request after first overflow", int'(reset_req), 0);
            cyc();
            chk("R4 pulse width", int'(nmi_pulse), 0);
            trip = 0;
            extra = 0;
            for (int i = l + 2; i <= 2 * l + 2; i++) begin
                cyc();
                if (nmi_pulse) extra++;
                if (reset_req && trip == 0) trip = i;
            end
            chk("R5 second overflow trips", trip, 2 * l);
            chk("R5 no second pulse", extra, 0);
            do_kick(s);
            cyc();
            chk("R5 request survives clear", int'(reset_req), 1);
        end

        // R6: clear after first overflow re-arms first stage.
        do_reset();
        do_kick(1);
        wait_nmi(64, n);
        chk("R6 setup overflow", n, 32);
        for (int i = 0; i < 7; i++) cyc();
        do_kick(1);
        chk("R6 clear drops warning", int'(warned), 0);
        wait_nmi(64, n);
        chk("R6 next overflow is first", n, 32);
        chk("R6 no request", int'(reset_req), 0);

        // R7: clear exactly in the wrap cycle.
        do_reset();
        do_kick(0);
        for (int i = 0; i < 15; i++) cyc();
        do_kick(0);
        chk("R7 no pulse on coincident clear", int'(nmi_pulse), 0);
        chk("R7 no warning on coincident clear", int'(warned), 0);
        wait_nmi(64, n);
        chk("R7 next overflow from late clear", n, 16);

        // R8: select change mid-period is deferred.
        do_reset();
        do_kick(0);
        for (int i = 0; i < 5; i++) cyc();
        period_sel = SW'(4);
        wait_nmi(64, n);
        chk("R8 running period unchanged", n, 11);
        do_kick(4);
        wait_nmi(600, n);
        chk("R8 new period after clear", n, 256);

        // R9: disable.
        do_reset();
        do_kick(0);
        wait_nmi(64, n);
        chk("R9 setup overflow", n, 16);
        en = 1'b0;
        cyc();
        chk("R9 disable drops warning", int'(warned), 0);
        extra = 0;
        for (int i = 0; i < 100; i++) begin
            cyc();
            if (nmi_pulse || reset_req || warned) extra++;
        end
        chk("R9 quiet while disabled", extra, 0);
        en = 1'b1;
        do_kick(0);
        wait_nmi(64, n);
        chk("R9 resumes after enable", n, 16);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule